// File: doc/BRIEF.md
# Sample Offset and Output Format Stage

This block sits at the back end of a converter data path. It takes each 14-bit two's-complement sample and adds a small signed correction in LSBs. It clamps the sum to the 14-bit range, can complement the clamped value, and then recodes it into the number format the downstream receiver expects. The result leaves on a registered output word with its own valid flag, two clock edges after the sample arrives.

The offset, invert, format and disable controls are sampled on the same edge as the sample they travel with. Settings therefore change cleanly on a sample boundary, even while samples stream back to back. The disable control blanks the output to an all-zero word with valid low. This lets a downstream receiver treat the lane as idle without any change to the data path.

Top module: `sample_fmt_stage`

## Requirements
- R1: With format 01 and invert off, each valid sample yields the 14-bit two's-complement sum of the sample and the sign-extended 6-bit offset (offset range +31 to -32; 6'h3D is -3).
- R2: A sum above +8191 is clamped to +8191 (14'h1FFF) instead of wrapping.
- R3: A sum below -8192 is clamped to -8192 (14'h2000) instead of wrapping.
- R4: With the invert bit set, the clamped sum is bitwise complemented before format conversion.
- R5: Format code 01 passes the (possibly inverted) clamped value through as two's complement.
- R6: Format codes 00 and 11 both give offset binary, formed by flipping bit 13 of the two's-complement value.
- R7: Format code 10 gives Gray code, computed from the offset-binary value b as b ^ (b >> 1).
- R8: A sample with valid high and disable low appears at the output with valid high exactly two rising edges later. When valid is low, valid out goes low two edges later and the output word holds its last value.
- R9: A sample accompanied by disable high produces an all-zero output word with valid low, two edges later. The following enabled sample is not affected.
- R10: While reset (active low, synchronous) is asserted, the output word is zero and valid out is low. The internal controls return to zero offset and format 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Sample valid |
| in_smp | input | 14 | Two's-complement input sample |
| ofs_lsb | input | 6 | Signed offset in LSBs, two's complement |
| fmt_sel | input | 2 | Output format: 00/11 offset binary, 01 two's complement, 10 Gray |
| inv_en | input | 1 | Complement the data before formatting |
| out_dis | input | 1 | Blank the output (zero word, valid low) |
| out_word | output | 14 | Formatted output word |
| out_vld | output | 1 | Output word valid |

## Verification
Blanking and clamping can act on the same sample. Disable has to override a word that has just been clamped in the first stage, and the next sample must still come out whole. The bench drives a full-scale sample with a positive offset and disable set. On the very next cycle it drives an ordinary enabled sample. It expects a zero word with valid low, followed one cycle later by the correct sum with valid high. The vector table is streamed back to back, so every control change also lands on a cycle where the previous sample is still in flight.

// File: rtl/sample_fmt_pkg.sv
// Package: shared format codes for the sample offset and format stage.
// Assumes a 2-bit format selector; both offset-binary codes are listed.
package sample_fmt_pkg;

    typedef enum logic [1:0] {
        FMT_OFSBIN_A = 2'b00,
        FMT_TWOS     = 2'b01,
        FMT_GRAY     = 2'b10,
        FMT_OFSBIN_B = 2'b11
    } fmt_e;

endpackage

// File: rtl/ofs_sat_add.sv
// Module: ofs_sat_add
// Adds a sign-extended offset to a two's-complement sample and clamps the
// result to the sample width. Assumes OW < DW. Purely combinational.
module ofs_sat_add #(
    parameter int DW = 14,
    parameter int OW = 6
) (
    input  logic [DW-1:0] smp,
    input  logic [OW-1:0] ofs,
    output logic [DW-1:0] sum
);

    localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0] wide;

    // One guard bit: sign-extend both operands and add.
    always_comb begin
        wide = {smp[DW-1], smp} + {{(DW+1-OW){ofs[OW-1]}}, ofs};
    end

    // Clamp when the guard bit disagrees with the result sign bit.
    always_comb begin
        if (wide[DW] != wide[DW-1]) begin
            sum = wide[DW] ? NEG_LIM : POS_LIM;
        end else begin
            sum = wide[DW-1:0];
        end
    end

endmodule

// File: rtl/fmt_conv.sv
// Module: fmt_conv
// Optionally complements a two's-complement word, then recodes it as two's
// complement, offset binary or Gray code. Purely combinational.
module fmt_conv
    import sample_fmt_pkg::*;
#(
    parameter int DW = 14
) (
    input  logic [DW-1:0] val,
    input  logic          inv,
    input  logic [1:0]    fmt,
    output logic [DW-1:0] word
);

    logic [DW-1:0] pol;
    logic [DW-1:0] obin;
    logic [DW-1:0] gray;

    // Inversion is applied before any recoding.
    always_comb begin
        pol = inv ? ~val : val;
    end

    // Offset binary: flip the sign bit.
    always_comb begin
        obin = {~pol[DW-1], pol[DW-2:0]};
    end

    // Gray code bitwise from the offset-binary value.
    assign gray[DW-1] = obin[DW-1];
    for (genvar g = 0; g < DW-1; g++) begin : g_gray
        assign gray[g] = obin[g+1] ^ obin[g];
    end

    // Select the requested output format.
    always_comb begin
        unique case (fmt_e'(fmt))
            FMT_TWOS:     word = pol;
            FMT_GRAY:     word = gray;
            FMT_OFSBIN_A,
            FMT_OFSBIN_B: word = obin;
            default:      word = obin;
        endcase
    end

endmodule

// File: rtl/sample_fmt_stage.sv
// Module: sample_fmt_stage
// Two-stage pipeline. The first edge captures the clamped offset sum together
// with the sample's controls. The second edge registers the inverted and
// formatted word, or a blank word when disable was set. Reset is synchronous
// and active low. All controls are sampled alongside the sample they affect.
module sample_fmt_stage
    import sample_fmt_pkg::*;
#(
    parameter int DW = 14,
    parameter int OW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_smp,
    input  logic [OW-1:0] ofs_lsb,
    input  logic [1:0]    fmt_sel,
    input  logic          inv_en,
    input  logic          out_dis,
    output logic [DW-1:0] out_word,
    output logic          out_vld
);

    logic [DW-1:0] sum_c;
    logic [DW-1:0] s1_sum;
    logic [1:0]    s1_fmt;
    logic          s1_inv;
    logic          s1_vld;
    logic          s1_dis;
    logic [DW-1:0] word_c;

    ofs_sat_add #(.DW(DW), .OW(OW)) u_add (
        .smp (in_smp),
        .ofs (ofs_lsb),
        .sum (sum_c)
    );

    // Stage 1: capture clamped sum and its controls on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sum <= '0;
            s1_fmt <= FMT_TWOS;
            s1_inv <= 1'b0;
        end else if (in_vld) begin
            s1_sum <= sum_c;
            s1_fmt <= fmt_sel;
            s1_inv <= inv_en;
        end
    end

    // Stage 1: track valid and disable on every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_dis <= 1'b0;
        end else begin
            s1_vld <= in_vld;
            s1_dis <= out_dis;
        end
    end

    fmt_conv #(.DW(DW)) u_fmt (
        .val  (s1_sum),
        .inv  (s1_inv),
        .fmt  (s1_fmt),
        .word (word_c)
    );

    // Stage 2: register formatted word, blank when disabled, hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            out_vld  <= 1'b0;
        end else if (s1_dis) begin
            out_word <= '0;
            out_vld  <= 1'b0;
        end else if (s1_vld) begin
            out_word <= word_c;
            out_vld  <= 1'b1;
        end else begin
            out_vld  <= 1'b0;
        end
    end

endmodule

// File: rtl/sample_fmt_stage_chk.sv
// Module: sample_fmt_stage_chk
// Port-level timing and value properties for sample_fmt_stage, bound to it.
module sample_fmt_stage_chk #(
    parameter int DW = 14,
    parameter int OW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_vld,
    input logic [DW-1:0] in_smp,
    input logic [OW-1:0] ofs_lsb,
    input logic [1:0]    fmt_sel,
    input logic          inv_en,
    input logic          out_dis,
    input logic [DW-1:0] out_word,
    input logic          out_vld
);

    localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    logic rst_seen_low = 1'b0;

    // Remember whether reset was low at the last rising edge.
    always @(posedge clk) begin
        rst_seen_low <= !rst_n;
    end

    // R10: outputs are cleared after an edge with reset asserted.
    always @(negedge clk) begin
        if (rst_seen_low) begin
            a_r10_reset_clear: assert (!out_vld && out_word == '0)
                else $error("a_r10_reset_clear");
        end
    end

    // R8: enabled sample gives valid two edges later.
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !out_dis) |=> ##1 out_vld);

    // R8: idle cycle gives valid low and a held word two edges later.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && !out_dis) |=> ##1 (!out_vld && $stable(out_word)));

    // R9: disabled cycle blanks the output two edges later.
    a_r9_blank: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |=> ##1 (!out_vld && out_word == '0));

    // R2: full-scale positive sample with non-negative offset clamps high.
    a_r2_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !out_dis && fmt_sel == 2'b01 && !inv_en &&
         in_smp == POS_LIM && !ofs_lsb[OW-1]) |=> ##1 (out_word == POS_LIM));

    // R3: full-scale negative sample with negative offset clamps low.
    a_r3_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !out_dis && fmt_sel == 2'b01 && !inv_en &&
         in_smp == NEG_LIM && ofs_lsb[OW-1]) |=> ##1 (out_word == NEG_LIM));

endmodule

bind sample_fmt_stage sample_fmt_stage_chk #(.DW(DW), .OW(OW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_smp   (in_smp),
    .ofs_lsb  (ofs_lsb),
    .fmt_sel  (fmt_sel),
    .inv_en   (inv_en),
    .out_dis  (out_dis),
    .out_word (out_word),
    .out_vld  (out_vld)
);

// File: tb/sample_fmt_stage_tb.sv
// Bench: streams a table of hand-computed vectors back to back, then runs
// directed tests for reset, idle hold, blanking and blank-during-clamp.
module sample_fmt_stage_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [13:0] in_smp = '0;
    logic [5:0]  ofs_lsb = '0;
    logic [1:0]  fmt_sel = 2'b01;
    logic        inv_en = 1'b0;
    logic        out_dis = 1'b0;
    logic [13:0] out_word;
    logic        out_vld;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sample_fmt_stage u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_smp   (in_smp),
        .ofs_lsb  (ofs_lsb),
        .fmt_sel  (fmt_sel),
        .inv_en   (inv_en),
        .out_dis  (out_dis),
        .out_word (out_word),
        .out_vld  (out_vld)
    );

    // Vector: {sample[14], offset[6], format[2], invert[1], expected[14]}
    localparam int NV = 17;
    localparam logic [36:0] VEC [NV] = '{
        {14'h0100, 6'h05, 2'b01, 1'b0, 14'h0105},  // R1 +5
        {14'h0100, 6'h3D, 2'b01, 1'b0, 14'h00FD},  // R1 -3
        {14'h1FFF, 6'h01, 2'b01, 1'b0, 14'h1FFF},  // R2
        {14'h1FF0, 6'h1F, 2'b01, 1'b0, 14'h1FFF},  // R2 +31
        {14'h2000, 6'h3F, 2'b01, 1'b0, 14'h2000},  // R3
        {14'h2010, 6'h20, 2'b01, 1'b0, 14'h2000},  // R3 -32
        {14'h0000, 6'h00, 2'b00, 1'b0, 14'h2000},  // R6 code 00
        {14'h0000, 6'h00, 2'b11, 1'b0, 14'h2000},  // R6 code 11
        {14'h3FFF, 6'h00, 2'b00, 1'b0, 14'h1FFF},  // R6
        {14'h0000, 6'h00, 2'b10, 1'b0, 14'h3000},  // R7
        {14'h1FFF, 6'h00, 2'b10, 1'b0, 14'h2000},  // R7
        {14'h2000, 6'h00, 2'b10, 1'b0, 14'h0000},  // R7
        {14'h0005, 6'h00, 2'b10, 1'b0, 14'h3007},  // R7
        {14'h0100, 6'h05, 2'b01, 1'b1, 14'h3EFA},  // R4 R5
        {14'h1FFF, 6'h01, 2'b01, 1'b1, 14'h2000},  // R4 after clamp
        {14'h0000, 6'h00, 2'b00, 1'b1, 14'h1FFF},  // R4 then offset binary
        {14'h0000, 6'h00, 2'b10, 1'b1, 14'h1000}   // R4 then Gray
    };

    task automatic check(input string req, input logic [13:0] act_w,
                         input logic [13:0] exp_w, input logic act_v,
                         input logic exp_v);
        n_chk++;
        if (act_w !== exp_w || act_v !== exp_v) begin
            n_err++;
            $display("FAIL %s: word %h valid %b, expected word %h valid %b",
                     req, act_w, act_v, exp_w, exp_v);
        end
    endtask

    task automatic drive(input logic v, input logic [13:0] s,
                         input logic [5:0] o, input logic [1:0] f,
                         input logic i, input logic d);
        in_vld  = v;
        in_smp  = s;
        ofs_lsb = o;
        fmt_sel = f;
        inv_en  = i;
        out_dis = d;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", out_word, 14'h0000, out_vld, 1'b0);
        rst_n = 1'b1;

        // R1-R7 table streamed back to back; checks also cover R8 latency
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) begin
                check("R8 table", out_word, VEC[i-2][13:0], out_vld, 1'b1);
            end
            if (i < NV) begin
                drive(1'b1, VEC[i][36:23], VEC[i][22:17], VEC[i][16:15],
                      VEC[i][14], 1'b0);
            end else begin
                drive(1'b0, 14'h0, 6'h0, 2'b01, 1'b0, 1'b0);
            end
            @(negedge clk);
        end

        // R8: idle -> valid low, word held at the last value
        check("R8 idle hold", out_word, 14'h1000, out_vld, 1'b0);
        @(negedge clk);
        check("R8 idle hold", out_word, 14'h1000, out_vld, 1'b0);

        // R9 with R2: blank a clamping sample, next sample unaffected
        drive(1'b1, 14'h1FFF, 6'h1F, 2'b01, 1'b0, 1'b1);
        @(negedge clk);
        drive(1'b1, 14'h0100, 6'h05, 2'b01, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b0, 14'h0, 6'h0, 2'b01, 1'b0, 1'b0);
        check("R9 blank during clamp", out_word, 14'h0000, out_vld, 1'b0);
        @(negedge clk);
        check("R9 next sample", out_word, 14'h0105, out_vld, 1'b1);

        // R9: disable with no valid also blanks
        drive(1'b0, 14'h0, 6'h0, 2'b01, 1'b0, 1'b1);
        @(negedge clk);
        drive(1'b0, 14'h0, 6'h0, 2'b01, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 blank idle", out_word, 14'h0000, out_vld, 1'b0);

        // R10: reset mid-run clears the output and restores format 01
        drive(1'b1, 14'h0123, 6'h00, 2'b01, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R5 before reset", out_word, 14'h0123, out_vld, 1'b1);
        drive(1'b0, 14'h0, 6'h0, 2'b01, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid-run reset", out_word, 14'h0000, out_vld, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_err);
        $finish;
    end

endmodule